// File: doc/BRIEF.md
# Timing Reference Loss Monitor

This block watches the timing reference that feeds clock recovery and decides whether the reference has gone quiet. A coarse watchdog counts master-clock cycles in large units. If no qualifying arrival event is seen within a programmed number of units, it raises a sticky loss flag. The arrival event is either a timing-reference cell strobe or an 8 kHz marker strobe, and a control bit picks which one counts.

The block also divides the master clock down to an 8 kHz reference tick using a programmable divisor. It drives a free-run indication in one of three modes: forced high, following an external reference-fail status, or forced low.

Software uses a small word-wide register port with four addresses. Address 0 holds the divisor. Address 1 holds the watchdog control. Address 2 holds the free-run mode. Address 3 holds the status word, which is write-one-to-clear.

The watchdog is a two-state machine:
- **WD_WATCH** counts prescaler cycles and units. A qualifying event restarts both counts.
- When the last unit ends, the transition *expire* moves the machine to **WD_LOST**, which holds the loss flag.
- Writing 1 to status bit 0 takes the transition *rearm* back to **WD_WATCH**, with both counts at zero.
- In **WD_LOST**, qualifying events have no effect.

Top module: `tref_loss_monitor`

## Requirements
- R1: After reset, the registers read as follows: divisor 0x2000, watchdog control 0x0001, free-run mode 0x0002, status 0x0000. The outputs `loss_o`, `freerun_o` and `tick8k_o` are low.
- R2: The tick is one cycle wide. With divisor value D (address 0, bits 13:0) in force, successive ticks are exactly D+2 master-clock cycles apart (D=0 gives 2, D=0x3FFE gives 16384).
- R3: A divisor written mid-period does not change the current period. The new value governs the period that starts at the next tick.
- R4: The watchdog timeout is T, in address 1 bits 9:0. In WD_WATCH, `loss_o` rises exactly T·2^UNIT_W cycles after the last restart if no qualifying event arrives.
- R5: T=0 behaves as T=1, so the timeout is one unit.
- R6: A qualifying event restarts the prescaler and the unit count. An event in the same cycle as expiry wins, so `loss_o` stays low.
- R7: Address 1 bit 10 selects the event source: 0 selects the cell strobe and 1 selects the marker strobe. The other strobe has no effect on the timeout.
- R8: `loss_o` (status bit 0) is sticky in WD_LOST. Writing 1 to status bit 0 clears it and restarts the timeout. Writing 0 leaves it set.
- R9: With free-run mode M (address 2, bits 1:0):
  - M=00 drives `freerun_o` high.
  - M=01 drives it equal to `ref_fail_i`.
  - M=10 and M=11 drive it low.
- R10: Readback returns only the implemented fields: 14 bits at address 0, 11 bits at address 1, 2 bits at address 2 and 1 bit at address 3. Every other bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational from address) |
| ev_cell_i | input | 1 | Timing-reference cell arrival strobe |
| ev_mark_i | input | 1 | 8 kHz marker arrival strobe |
| ref_fail_i | input | 1 | Reference-fail status used by follow mode |
| tick8k_o | output | 1 | Divided 8 kHz reference pulse |
| loss_o | output | 1 | Sticky loss-of-reference flag |
| freerun_o | output | 1 | Free-run indication |

## Verification
The hardest case to reach from the ports is an arrival event that lands in exactly the cycle where the last unit expires. That cycle is several tens of thousands of cycles after the restart, and an event one cycle early or late tests a different rule. The bench therefore builds the monitor with a small unit width. It starts each scenario from a known restart: a clear write or an event strobe. It then counts edges to place the strobe precisely on the expiry edge, and checks the flag one cycle before and exactly at the expected rise.

// File: rtl/tref_pkg.sv
package tref_pkg;

    localparam int REG_W = 16;

    typedef enum logic [1:0] {
        ADDR_DIV  = 2'd0,
        ADDR_TREF = 2'd1,
        ADDR_FRUN = 2'd2,
        ADDR_STAT = 2'd3
    } reg_addr_e;

    typedef enum logic {
        WD_WATCH = 1'b0,
        WD_LOST  = 1'b1
    } wd_state_e;

    typedef enum logic [1:0] {
        FR_FORCE_ON      = 2'b00,
        FR_FOLLOW        = 2'b01,
        FR_FORCE_OFF     = 2'b10,
        FR_FORCE_OFF_ALT = 2'b11
    } fr_mode_e;

endpackage

// File: rtl/tref_ref_divider.sv
module tref_ref_divider #(
    parameter int DIV_W     = 14,
    parameter int DIV_RESET = 'h2000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_val,
    output logic             tick_o
);
    localparam int CNT_W = DIV_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] term_q;
    logic             at_term;

    assign at_term = (cnt_q == term_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            term_q <= CNT_W'(DIV_RESET) + CNT_W'(1);
        end else if (at_term) begin
            cnt_q  <= '0;
            term_q <= CNT_W'(div_val) + CNT_W'(1);
        end else begin
            cnt_q  <= cnt_q + CNT_W'(1);
        end
    end

    always_comb begin
        tick_o = at_term;
    end

    // R2: terminal value is at least 1, so a tick never repeats next cycle
    a_r2_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

    // R2: count never runs past the active terminal value
    a_r2_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= term_q);

endmodule

// File: rtl/tref_loss_watchdog.sv
module tref_loss_watchdog
    import tref_pkg::*;
#(
    parameter int UNIT_W = 16,
    parameter int TO_W   = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [TO_W-1:0] timeout,
    input  logic            src_sel,
    input  logic            ev_cell,
    input  logic            ev_mark,
    input  logic            clr,
    output logic            loss_o
);
    wd_state_e         state_q, state_d;
    logic [UNIT_W-1:0] presc_q, presc_d;
    logic [TO_W-1:0]   units_q, units_d;
    logic [TO_W-1:0]   limit;
    logic              qual_ev;
    logic              unit_end;
    logic              last_unit;

    assign qual_ev   = src_sel ? ev_mark : ev_cell;
    assign limit     = (timeout == '0) ? TO_W'(1) : timeout;
    assign unit_end  = &presc_q;
    assign last_unit = (units_q >= limit - TO_W'(1));

    always_comb begin
        state_d = state_q;
        presc_d = presc_q;
        units_d = units_q;
        unique case (state_q)
            WD_WATCH: begin
                if (qual_ev) begin
                    presc_d = '0;
                    units_d = '0;
                end else if (unit_end) begin
                    presc_d = '0;
                    if (last_unit) begin
                        state_d = WD_LOST;
                        units_d = '0;
                    end else begin
                        units_d = units_q + TO_W'(1);
                    end
                end else begin
                    presc_d = presc_q + UNIT_W'(1);
                end
            end
            WD_LOST: begin
                presc_d = '0;
                units_d = '0;
                if (clr) begin
                    state_d = WD_WATCH;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WD_WATCH;
            presc_q <= '0;
            units_q <= '0;
        end else begin
            state_q <= state_d;
            presc_q <= presc_d;
            units_q <= units_d;
        end
    end

    always_comb begin
        loss_o = (state_q == WD_LOST);
    end

    // R6: a qualifying event while watching leaves both counts at zero
    a_r6_event_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WD_WATCH && qual_ev) |=>
            (presc_q == '0 && units_q == '0 && !loss_o));

    // R8: the flag stays set until a clear write
    a_r8_loss_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (loss_o && !clr) |=> loss_o);

    // R8: a clear write rearms the watchdog from zero
    a_r8_clear_rearms: assert property (@(posedge clk) disable iff (!rst_n)
        (loss_o && clr) |=> (!loss_o && presc_q == '0 && units_q == '0));

endmodule

// File: rtl/tref_freerun_gen.sv
module tref_freerun_gen
    import tref_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       ref_fail,
    output logic       freerun_o
);
    fr_mode_e mode_e;

    assign mode_e = fr_mode_e'(mode);

    always_comb begin
        unique case (mode_e)
            FR_FORCE_ON:      freerun_o = 1'b1;
            FR_FOLLOW:        freerun_o = ref_fail;
            FR_FORCE_OFF,
            FR_FORCE_OFF_ALT: freerun_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/tref_loss_monitor.sv
module tref_loss_monitor
    import tref_pkg::*;
#(
    parameter int UNIT_W    = 16,
    parameter int DIV_W     = 14,
    parameter int TO_W      = 10,
    parameter int DIV_RESET = 'h2000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr_i,
    input  logic [1:0]  reg_addr_i,
    input  logic [15:0] reg_wdata_i,
    output logic [15:0] reg_rdata_o,
    input  logic        ev_cell_i,
    input  logic        ev_mark_i,
    input  logic        ref_fail_i,
    output logic        tick8k_o,
    output logic        loss_o,
    output logic        freerun_o
);
    localparam int SRC_BIT = TO_W;

    reg_addr_e        addr_e;
    logic [DIV_W-1:0] div_q;
    logic [TO_W-1:0]  tmo_q;
    logic             src_q;
    logic [1:0]       frm_q;
    logic             clr_w;
    logic             loss_w;

    assign addr_e = reg_addr_e'(reg_addr_i);
    assign clr_w  = reg_wr_i && (addr_e == ADDR_STAT) && reg_wdata_i[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= DIV_W'(DIV_RESET);
            tmo_q <= TO_W'(1);
            src_q <= 1'b0;
            frm_q <= FR_FORCE_OFF;
        end else if (reg_wr_i) begin
            unique case (addr_e)
                ADDR_DIV:  div_q <= reg_wdata_i[DIV_W-1:0];
                ADDR_TREF: begin
                    tmo_q <= reg_wdata_i[TO_W-1:0];
                    src_q <= reg_wdata_i[SRC_BIT];
                end
                ADDR_FRUN: frm_q <= reg_wdata_i[1:0];
                ADDR_STAT: ;
            endcase
        end
    end

    always_comb begin
        reg_rdata_o = '0;
        unique case (addr_e)
            ADDR_DIV:  reg_rdata_o[DIV_W-1:0] = div_q;
            ADDR_TREF: begin
                reg_rdata_o[TO_W-1:0] = tmo_q;
                reg_rdata_o[SRC_BIT]  = src_q;
            end
            ADDR_FRUN: reg_rdata_o[1:0] = frm_q;
            ADDR_STAT: reg_rdata_o[0]   = loss_w;
        endcase
    end

    tref_ref_divider #(
        .DIV_W    (DIV_W),
        .DIV_RESET(DIV_RESET)
    ) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .div_val(div_q),
        .tick_o (tick8k_o)
    );

    tref_loss_watchdog #(
        .UNIT_W(UNIT_W),
        .TO_W  (TO_W)
    ) u_wd (
        .clk    (clk),
        .rst_n  (rst_n),
        .timeout(tmo_q),
        .src_sel(src_q),
        .ev_cell(ev_cell_i),
        .ev_mark(ev_mark_i),
        .clr    (clr_w),
        .loss_o (loss_w)
    );

    tref_freerun_gen u_fr (
        .mode     (frm_q),
        .ref_fail (ref_fail_i),
        .freerun_o(freerun_o)
    );

    assign loss_o = loss_w;

    // R8: writing zero to the status word never clears a set flag
    a_r8_zero_write_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (loss_o && reg_wr_i && addr_e == ADDR_STAT && !reg_wdata_i[0]) |=> loss_o);

endmodule

// File: tb/tref_loss_monitor_bench.sv
module tref_loss_monitor_bench;

    localparam int UW   = 4;
    localparam int UNIT = 1 << UW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        ev_cell = 1'b0;
    logic        ev_mark = 1'b0;
    logic        ref_fail = 1'b0;
    logic        tick8k;
    logic        loss;
    logic        freerun;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    tref_loss_monitor #(.UNIT_W(UW)) u_tref_loss_monitor (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
        .ev_cell_i(ev_cell), .ev_mark_i(ev_mark), .ref_fail_i(ref_fail),
        .tick8k_o(tick8k), .loss_o(loss), .freerun_o(freerun)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        edges(1);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        reg_addr = a;
        #1;
        v = int'(reg_rdata);
    endtask

    task automatic pulse_cell();
        ev_cell = 1'b1; edges(1); ev_cell = 1'b0;
    endtask

    task automatic pulse_mark();
        ev_mark = 1'b1; edges(1); ev_mark = 1'b0;
    endtask

    // counts edges until the next tick is visible
    task automatic next_tick(output int n);
        n = 0;
        do begin edges(1); n++; end while (!tick8k);
    endtask

    // writes the divisor at a tick and counts edges to the following tick
    task automatic write_div_count(input logic [15:0] d, output int n);
        reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = d;
        edges(1);
        reg_wr = 1'b0;
        n = 1;
        while (!tick8k) begin edges(1); n++; end
    endtask

    task automatic t_reset();
        int v;
        check("R1 loss", loss, 0);
        check("R1 freerun", freerun, 0);
        check("R1 tick", tick8k, 0);
        rd(2'd0, v); check("R1 div reset", v, 'h2000);
        rd(2'd1, v); check("R1 ctrl reset", v, 'h0001);
        rd(2'd2, v); check("R1 frun reset", v, 'h0002);
        rd(2'd3, v); check("R1 stat reset", v, 0);
        edges(UNIT - 1); check("R4 reset unit before", loss, 0);
        edges(1);        check("R4 reset unit at", loss, 1);
    endtask

    task automatic t_sticky();
        int v;
        pulse_cell();
        edges(40);
        check("R8 sticky through events", loss, 1);
        wr(2'd3, 16'hFFFE);
        check("R8 zero write keeps", loss, 1);
        rd(2'd3, v); check("R10 stat read", v, 1);
        wr(2'd3, 16'h0001);
        check("R8 w1c clears", loss, 0);
    endtask

    task automatic t_timeout();
        wr(2'd1, 16'h0003);
        pulse_cell();
        edges(3 * UNIT - 1); check("R4 T=3 before", loss, 0);
        edges(1);            check("R4 T=3 at", loss, 1);
        wr(2'd3, 16'h0001);
        edges(3 * UNIT - 1); check("R8 rearm before", loss, 0);
        edges(1);            check("R8 rearm at", loss, 1);
    endtask

    task automatic t_zero();
        int v;
        wr(2'd1, 16'h0000);
        wr(2'd3, 16'h0001);
        edges(UNIT - 1); check("R5 zero before", loss, 0);
        edges(1);        check("R5 zero at", loss, 1);
        rd(2'd1, v); check("R5 ctrl reads zero", v, 0);
    endtask

    task automatic t_source();
        int v;
        // marker source, cell ignored (R7)
        wr(2'd1, 16'h0402);
        wr(2'd3, 16'h0001);
        pulse_mark();
        edges(20);
        pulse_cell();
        edges(10);  check("R7 cell ignored before", loss, 0);
        edges(1);   check("R7 cell ignored at", loss, 1);
        rd(2'd1, v); check("R10 ctrl read", v, 'h0402);
        // marker restarts (R6)
        wr(2'd3, 16'h0001);
        edges(20);
        pulse_mark();
        edges(2 * UNIT - 1); check("R6 marker restart before", loss, 0);
        edges(1);            check("R6 marker restart at", loss, 1);
        // cell source, marker ignored (R7)
        wr(2'd1, 16'h0002);
        wr(2'd3, 16'h0001);
        edges(10);
        pulse_mark();
        edges(2 * UNIT - 12); check("R7 marker ignored before", loss, 0);
        edges(1);             check("R7 marker ignored at", loss, 1);
    endtask

    task automatic t_race();
        wr(2'd3, 16'h0001);
        edges(2 * UNIT - 1);
        pulse_cell();
        check("R6 event on expiry wins", loss, 0);
        edges(2 * UNIT - 1); check("R6 after race before", loss, 0);
        edges(1);            check("R6 after race at", loss, 1);
    endtask

    task automatic t_freerun();
        int v;
        ref_fail = 1'b1;
        wr(2'd2, 16'h0000); check("R9 mode 00", freerun, 1);
        wr(2'd2, 16'h0001); check("R9 mode 01 fail", freerun, 1);
        ref_fail = 1'b0; #1;
        check("R9 mode 01 ok", freerun, 0);
        ref_fail = 1'b1;
        wr(2'd2, 16'hFFFE); check("R9 mode 10", freerun, 0);
        rd(2'd2, v); check("R10 frun masked", v, 2);
        wr(2'd2, 16'h0003); check("R9 mode 11", freerun, 0);
        ref_fail = 1'b0;
    endtask

    task automatic t_divider();
        int n, v;
        wr(2'd0, 16'hC003);
        rd(2'd0, v); check("R10 div masked", v, 'h0003);
        next_tick(n);
        next_tick(n); check("R2 period D=3", n, 5);
        edges(1);     check("R2 tick single cycle", tick8k, 0);
        next_tick(n); check("R2 period D=3 again", n, 4);
        write_div_count(16'h0007, n); check("R3 old period kept", n, 5);
        next_tick(n); check("R3 new period D=7", n, 9);
        write_div_count(16'h0000, n); check("R3 old period D=7", n, 9);
        next_tick(n); check("R2 period D=0", n, 2);
        write_div_count(16'h3FFE, n); check("R3 old period D=0", n, 2);
        next_tick(n); check("R2 period D=3FFE", n, 16384);
    endtask

    initial begin
        edges(3);
        rst_n = 1'b1;
        t_reset();
        t_sticky();
        t_timeout();
        t_zero();
        t_source();
        t_race();
        t_freerun();
        t_divider();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule